// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the test access port that sits between a chip's four-wire serial test pins and its core. It runs the sixteen-state test controller on a slow test clock, holds a five-bit instruction, and routes the serial data path through one of three data registers. Those are a 32-bit identification register, a one-bit bypass stage, or an external boundary-scan chain whose serial output comes back into the block. Mode controls for the pads leave the block as well: a test-mode select that takes over the pad/core signals, a clamp flag and a tri-state flag. The boundary chain also gets capture, shift and update strobes.

Input sampling happens on the rising edge of the test clock. The serial output and its output enable change only on the falling edge. An active-low asynchronous reset puts the port back into its idle state with no clock needed. The port stays idle for as long as that pin is held low. The idle state is system mode with the identification register selected.

The controller states are: TAP_RESET (Test-Logic-Reset), TAP_IDLE (Run-Test/Idle), TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR, TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR and TAP_UPD_IR. On the rising edge each state moves as follows, with the TMS value shown in brackets:
- RESET goes to RESET [1] or IDLE [0].
- IDLE goes to SEL_DR [1] or stays in IDLE [0].
- SEL_DR goes to SEL_IR [1] or CAP_DR [0].
- CAP_DR goes to EX1_DR [1] or SH_DR [0].
- SH_DR goes to EX1_DR [1] or stays in SH_DR [0].
- EX1_DR goes to UPD_DR [1] or PAU_DR [0].
- PAU_DR goes to EX2_DR [1] or stays in PAU_DR [0].
- EX2_DR goes to UPD_DR [1] or SH_DR [0].
- UPD_DR goes to SEL_DR [1] or IDLE [0].
- SEL_IR goes to RESET [1] or CAP_IR [0].
- The IR column from CAP_IR to UPD_IR moves the same way as its DR counterpart.

Top module: `tap_port`

## Requirements
- R1: While `trst_n` is low, with or without test-clock edges, the controller is in Test-Logic-Reset. `test_mode`, `clamp_en`, `hiz_en`, `bsr_sel` and `tdo_oe` are 0, and the identification register is the selected data register.
- R2: The controller follows the sixteen-state transition table listed above. Pausing a data scan in Pause-DR and going back through Exit2-DR into Shift-DR continues the same shift without loss.
- R3: Five rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state. Four are not enough from Pause-DR. The falling edge in Test-Logic-Reset reloads the identification instruction.
- R4: The instruction register is 5 bits with no parity bit. Capture-IR loads 00001. In Shift-IR the first bit out on `tdo` is bit 0, and `tdi` enters at bit 4.
- R5: The active instruction, and every output decoded from it, changes only on the falling edge of `tck` in Update-IR or Test-Logic-Reset. It does not change during Shift-IR or at the rising edge that enters Update-IR.
- R6: The opcodes are 00000 for external test, 00001 for sample/preload, 00100 for clamp, 00101 for high-impedance, 00110 for identification and 11111 for bypass. Every other code selects the bypass register.
- R7: With the identification instruction active, Capture-DR loads the constant `ID_VALUE`, whose bit 0 is 1. Shift-DR presents it on `tdo` bit 0 first, followed by the bits taken from `tdi`.
- R8: With the bypass register selected, Capture-DR loads 0. Each bit shifted in on `tdi` reappears on `tdo` one shift later.
- R9: `test_mode` is 1 for the external-test and clamp opcodes. `clamp_en` is 1 only for clamp. `hiz_en` is 1 only for high-impedance.
- R10: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is 1 exactly during Shift-IR and Shift-DR.
- R11: `bsr_sel` is 1 for the external-test and sample/preload opcodes. Only while `bsr_sel` is 1, one of `bsr_capture`, `bsr_shift` or `bsr_update` goes high in Capture-DR, Shift-DR or Update-DR respectively. `tdo` then carries `bsr_so` during Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe | output | 1 | Output enable for tdo |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| test_mode | output | 1 | 1 selects test mode, 0 system mode |
| clamp_en | output | 1 | Clamp instruction active |
| hiz_en | output | 1 | Pad tri-state control |

## Verification
All 32 instruction codes are loaded in turn. Each one is followed by a 40-bit data scan with a code-dependent input pattern, so the first bits out tell apart the three data paths. The identification path gives the 32-bit constant. The bypass path gives a single leading 0 and then the input delayed by one. The boundary path gives a bench-modelled chain's captured 1010 and then the input delayed by four. Each instruction load also checks the captured 00001 and the arithmetic decode of the mode flags. Directed sequences cover the remaining corner cases: a scan paused and resumed, four versus five TMS-high edges from Pause-DR, the instruction outputs probed between the rising and falling edges of Update-IR, and reset with the clock stopped or running.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 5;

    typedef enum logic [3:0] {
        TAP_RESET, TAP_IDLE,
        TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
        TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_IDENT,
        DR_BOUNDARY
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 5'b00000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 5'b00001;
    localparam logic [IR_W-1:0] OP_CLAMP   = 5'b00100;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 5'b00101;
    localparam logic [IR_W-1:0] OP_IDENT   = 5'b00110;
    localparam logic [IR_W-1:0] OP_BYPASS  = 5'b11111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e st
);

    tap_state_e nxt;

    // state register: asynchronous reset, advance on the rising edge
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st <= TAP_RESET;
        else         st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            TAP_RESET:  nxt = tms ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:   nxt = tms ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_DR: nxt = tms ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: nxt = tms ? TAP_UPD_DR : TAP_PAU_DR;
            TAP_PAU_DR: nxt = tms ? TAP_EX2_DR : TAP_PAU_DR;
            TAP_EX2_DR: nxt = tms ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_IR: nxt = tms ? TAP_RESET  : TAP_CAP_IR;
            TAP_CAP_IR: nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: nxt = tms ? TAP_UPD_IR : TAP_PAU_IR;
            TAP_PAU_IR: nxt = tms ? TAP_EX2_IR : TAP_PAU_IR;
            TAP_EX2_IR: nxt = tms ? TAP_UPD_IR : TAP_SH_IR;
            TAP_UPD_IR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
        endcase
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e st,
    output logic       ir_lsb,
    output dr_sel_e    dr_sel,
    output logic       test_mode,
    output logic       clamp_en,
    output logic       hiz_en
);

    logic [IR_W-1:0] shreg;
    logic [IR_W-1:0] active;

    // shift stage: capture the fixed pattern, shift toward bit 0
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            shreg <= IR_CAPTURE;
        end else begin
            unique case (st)
                TAP_CAP_IR: shreg <= IR_CAPTURE;
                TAP_SH_IR:  shreg <= {tdi, shreg[IR_W-1:1]};
                default:    shreg <= shreg;
            endcase
        end
    end

    // active instruction: falling-edge update, identification after reset
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)               active <= OP_IDENT;
        else if (st == TAP_RESET)  active <= OP_IDENT;
        else if (st == TAP_UPD_IR) active <= shreg;
    end

    assign ir_lsb = shreg[0];

    always_comb begin
        test_mode = (active == OP_EXTEST) || (active == OP_CLAMP);
        clamp_en  = (active == OP_CLAMP);
        hiz_en    = (active == OP_HIGHZ);
        case (active)
            OP_EXTEST, OP_SAMPLE: dr_sel = DR_BOUNDARY;
            OP_IDENT:             dr_sel = DR_IDENT;
            default:              dr_sel = DR_BYPASS;
        endcase
    end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3E27
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e st,
    input  dr_sel_e    dr_sel,
    output logic       id_lsb,
    output logic       byp
);

    logic [ID_W-1:0] idreg;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            idreg <= ID_VALUE;
            byp   <= 1'b0;
        end else begin
            if (dr_sel == DR_IDENT) begin
                if (st == TAP_CAP_DR)     idreg <= ID_VALUE;
                else if (st == TAP_SH_DR) idreg <= {tdi, idreg[ID_W-1:1]};
            end
            if (dr_sel == DR_BYPASS) begin
                if (st == TAP_CAP_DR)     byp <= 1'b0;
                else if (st == TAP_SH_DR) byp <= tdi;
            end
        end
    end

    assign id_lsb = idreg[0];

endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3E27
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic bsr_so,
    output logic tdo,
    output logic tdo_oe,
    output logic bsr_sel,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic test_mode,
    output logic clamp_en,
    output logic hiz_en
);

    tap_state_e st;
    dr_sel_e    dr_sel;
    logic       ir_lsb, id_lsb, byp;
    logic       dr_bit, tdo_d, shifting;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .st(st)
    );

    tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st),
        .ir_lsb(ir_lsb), .dr_sel(dr_sel), .test_mode(test_mode),
        .clamp_en(clamp_en), .hiz_en(hiz_en)
    );

    tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st),
        .dr_sel(dr_sel), .id_lsb(id_lsb), .byp(byp)
    );

    always_comb begin
        unique case (dr_sel)
            DR_IDENT:    dr_bit = id_lsb;
            DR_BOUNDARY: dr_bit = bsr_so;
            default:     dr_bit = byp;
        endcase
        shifting = (st == TAP_SH_IR) || (st == TAP_SH_DR);
        if (st == TAP_SH_IR)      tdo_d = ir_lsb;
        else if (st == TAP_SH_DR) tdo_d = dr_bit;
        else                      tdo_d = 1'b0;
    end

    // serial output stage on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= tdo_d;
            tdo_oe <= shifting;
        end
    end

    assign bsr_sel     = (dr_sel == DR_BOUNDARY);
    assign bsr_capture = bsr_sel && (st == TAP_CAP_DR);
    assign bsr_shift   = bsr_sel && (st == TAP_SH_DR);
    assign bsr_update  = bsr_sel && (st == TAP_UPD_DR);

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
    import tap_pkg::*;
(
    input logic       tck,
    input logic       trst_n,
    input logic       tms,
    input tap_state_e st,
    input logic       tdo_oe,
    input logic       test_mode,
    input logic       clamp_en,
    input logic       hiz_en,
    input logic       bsr_sel,
    input logic       bsr_capture,
    input logic       bsr_shift,
    input logic       bsr_update
);

    p_idle_sysmode_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TAP_RESET && $past(st) == TAP_RESET) |-> (!test_mode && !clamp_en && !hiz_en && !bsr_sel));

    p_five_tms_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (st == TAP_RESET));

    p_instr_hold_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (st != TAP_UPD_IR && st != TAP_RESET) |->
            ($stable(test_mode) && $stable(clamp_en) && $stable(hiz_en) && $stable(bsr_sel)));

    p_mode_excl_r9: assert property (@(posedge tck) disable iff (!trst_n)
        !(hiz_en && test_mode) && (!clamp_en || test_mode));

    p_oe_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == (st == TAP_SH_IR || st == TAP_SH_DR));

    p_strobe_onehot_r11: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({bsr_capture, bsr_shift, bsr_update}));

    p_strobe_sel_r11: assert property (@(posedge tck) disable iff (!trst_n)
        (bsr_capture || bsr_shift || bsr_update) |-> bsr_sel);

endmodule

bind tap_port tap_port_chk u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st(st),
    .tdo_oe(tdo_oe), .test_mode(test_mode), .clamp_en(clamp_en), .hiz_en(hiz_en),
    .bsr_sel(bsr_sel), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update)
);

// File: tb/tap_port_test.sv
module tap_port_test;

    localparam logic [31:0] IDV = 32'h1A5C_3E27;

    logic tck = 1'b0, tck_en = 1'b0;
    logic trst_n = 1'b1, tms = 1'b1, tdi = 1'b0, bsr_so;
    logic tdo, tdo_oe, bsr_sel, bsr_capture, bsr_shift, bsr_update;
    logic test_mode, clamp_en, hiz_en;

    int nchk = 0, nerr = 0, upd_cnt = 0;
    bit done = 0;

    tap_port #(.ID_W(32), .ID_VALUE(IDV)) uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
        .tdo(tdo), .tdo_oe(tdo_oe), .bsr_sel(bsr_sel), .bsr_capture(bsr_capture),
        .bsr_shift(bsr_shift), .bsr_update(bsr_update), .test_mode(test_mode),
        .clamp_en(clamp_en), .hiz_en(hiz_en)
    );

    always begin
        #2;
        if (tck_en) tck = ~tck;
    end

    // model of a 4-cell external chain; strobes sampled at the falling edge
    logic [3:0] chain = 4'b0000;
    logic cap_p = 1'b0, sh_p = 1'b0;
    assign bsr_so = chain[0];
    always @(negedge tck) begin
        cap_p <= bsr_capture;
        sh_p  <= bsr_shift;
        if (bsr_update) upd_cnt <= upd_cnt + 1;
    end
    always @(posedge tck) begin
        if (cap_p)     chain <= 4'b1010;
        else if (sh_p) chain <= {tdi, chain[3:1]};
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic load_ir(input logic [4:0] code, output logic [4:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) begin
            cap[i] = tdo;
            tick(i == 4, code[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        #600000;
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [4:0]  cap;
        logic [63:0] dout, din, exp;
        int          u0;

        // R1: reset with the clock stopped
        #3 trst_n = 1'b0;
        #5;
        chk("R1 reset outputs", {tdo_oe, test_mode, clamp_en, hiz_en, bsr_sel}, 0);
        trst_n = 1'b1;
        #1 tck_en = 1'b1;
        @(negedge tck); #1;
        tick(0, 0);
        scan_dr(32, 64'h0, dout);
        chk("R1 R7 identification after reset", dout[31:0], IDV);

        // R10: output enable waits for the falling edge
        tick(1, 0); tick(0, 0);
        tms = 0;
        @(posedge tck); #1;
        chk("R10 oe before falling edge", tdo_oe, 0);
        @(negedge tck); #1;
        chk("R10 oe in shift", tdo_oe, 1);
        tick(1, 0); tick(1, 0); tick(0, 0);
        chk("R10 oe off in idle", tdo_oe, 0);

        // sweep of every instruction code: R4 R6 R7 R8 R9 R11
        for (int c = 0; c < 32; c++) begin
            logic [4:0] code;
            code = 5'(c);
            load_ir(code, cap);
            chk("R4 capture pattern", cap, 5'b00001);
            chk("R9 test_mode", test_mode, (c == 0 || c == 4));
            chk("R9 clamp_en", clamp_en, (c == 4));
            chk("R9 hiz_en", hiz_en, (c == 5));
            chk("R11 bsr_sel", bsr_sel, (c == 0 || c == 1));
            din = {24'h0, 8'(c * 37 + 11), 32'hC3A5_0F96 ^ 32'(c * 32'h0101_0101)};
            u0 = upd_cnt;
            scan_dr(40, din, dout);
            if (c == 6)
                exp = {24'h0, din[7:0], IDV};
            else if (c == 0 || c == 1)
                exp = {24'h0, din[35:0], 4'b1010};
            else
                exp = {24'h0, din[38:0], 1'b0};
            if (c == 6)                chk("R7 identification scan", dout, exp);
            else if (c == 0 || c == 1) chk("R11 boundary scan", dout, exp);
            else                       chk("R6 R8 bypass scan", dout, exp);
            chk("R11 update strobe count", upd_cnt - u0, (c == 0 || c == 1) ? 1 : 0);
        end

        // R2: pause and resume a data scan
        load_ir(5'b00110, cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        dout = '0;
        for (int i = 0; i < 16; i++) begin
            dout[i] = tdo;
            tick(i == 15, 1'b0);
        end
        tick(0, 0); tick(0, 0);
        chk("R2 R10 oe off in pause", tdo_oe, 0);
        tick(1, 0); tick(0, 0);
        for (int i = 16; i < 32; i++) begin
            dout[i] = tdo;
            tick(i == 31, 1'b0);
        end
        tick(1, 0); tick(0, 0);
        chk("R2 resumed scan", dout[31:0], IDV);

        // R5: instruction holds until the falling edge of Update-IR
        load_ir(5'b00000, cap);
        chk("R9 external test mode", test_mode, 1);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) begin
            logic [4:0] nc;
            nc = 5'b00110;
            tick(i == 4, nc[i]);
            chk("R5 hold during shift", test_mode, 1);
        end
        tms = 1;
        @(posedge tck); #1;
        chk("R5 hold at rising edge of update", test_mode, 1);
        @(negedge tck); #1;
        chk("R5 change at falling edge", test_mode, 0);
        tick(0, 0);

        // R3: four vs five TMS-high edges from Pause-DR
        load_ir(5'b00100, cap);
        tick(1, 0); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) tick(1, 0);
        chk("R3 four edges keep instruction", {test_mode, clamp_en}, 2'b11);
        tick(1, 0);
        chk("R3 fifth edge resets", {test_mode, clamp_en, tdo_oe}, 0);
        tick(0, 0);
        scan_dr(32, 64'h0, dout);
        chk("R3 identification reloaded", dout[31:0], IDV);

        // R1: asynchronous reset mid-run, clock stopped
        load_ir(5'b00000, cap);
        tck_en = 1'b0;
        #3 trst_n = 1'b0;
        #1;
        chk("R1 async reset no clock", {test_mode, bsr_sel}, 0);
        trst_n = 1'b1;
        #1 tck_en = 1'b1;
        @(negedge tck); #1;

        // R1: reset held with the clock running
        load_ir(5'b00100, cap);
        trst_n = 1'b0;
        tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 0);
        chk("R1 held reset", {tdo_oe, test_mode, clamp_en}, 0);
        trst_n = 1'b1;
        tick(0, 0);
        scan_dr(32, 64'h0, dout);
        chk("R1 identification after held reset", dout[31:0], IDV);

        finish_run();
    end

endmodule